// File: doc/BRIEF.md
# Framed Serial Audio Transmitter

This block turns a stream of parallel audio samples into one serial data line and a frame sync. It keeps time with an externally supplied bit clock, which it oversamples on the system clock. Every output change is launched on the bit-clock edge opposite the one the receiver samples on. A frame is a run of word slots, and each slot holds a fixed number of bits. Static configuration inputs set how many slots a frame has, how long a word is, how many bit clocks separate the frame-sync edge from the first data bit, how wide and which polarity the sync pulse is, the level of the line when no data is sent, and whether bits go out MSB or LSB first. With these settings one engine produces I2S, left-justified and multi-slot TDM framing.

A per-slot mask marks slots to skip. A skipped slot carries the idle level and takes no sample from the input. Samples arrive as 32-bit words with the sample right-justified, and only the low word-length bits are sent. The input is valid/ready. `in_ready` is a single-cycle pulse at the start of each unmasked slot, and a sample moves only when `in_valid` is high in that same cycle. The source may hold `in_valid` high for as long as it likes and must keep `in_data` stable until the handshake. If `in_valid` is low when the pulse comes, that slot is not retried: it carries the idle level and `underrun` pulses.

Top module: `tdm_frame_tx`

## Requirements
- R1: A frame lasts `cfg_words` × `cfg_bits` bit clocks, where `cfg_words` is 1..32 and `cfg_bits` is 1..32. Slot s, bit b of a frame falls at data position s·`cfg_bits`+b, and frames follow one another without gaps.
- R2: The first data bit of slot 0 is launched `cfg_delay` bit clocks after the bit that starts the frame sync, with `cfg_delay` below the frame length. With a delay of 1 or more, the last bits of a frame spill into the start of the next frame.
- R3: Frame sync is active for the first max(1, `cfg_sync_len`) bit clocks of each frame: a length of 0 gives one bit clock.
- R4: `cfg_sync_active_high`=1 makes the sync pulse high and its rest level low. A value of 0 inverts both.
- R5: Bit s of `cfg_slot_mask` set to 1 skips slot s. The slot carries the idle level and no sample is taken. A 0 bit sends the slot.
- R6: `sdata` carries `cfg_idle_level` in the bit clocks before the first data bit after enable and during skipped or underrun slots.
- R7: `cfg_lsb_first`=0 sends the word MSB first (bit `cfg_bits`-1 first). A value of 1 sends bit 0 first.
- R8: Only bits [`cfg_bits`-1:0] of `in_data` are sent. The upper bits have no effect.
- R9: If `in_valid` is low in the cycle where `in_ready` pulses, `underrun` is high for exactly the next cycle and that slot carries the idle level.
- R10: `cfg_sample_rising`=1 launches `fsync`/`sdata` on falling `bclk` edges, and 0 launches them on rising edges. The outputs hold steady across the receiver's sampling edge.
- R11: While `cfg_enable` is low, `fsync` rests inactive and `sdata` sits at the idle level, whatever `bclk` does. The first launch edge after enable starts a new frame at position 0.
- R12: `in_ready` pulses for one cycle at a launch edge only, and only at the first bit of an unmasked slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `bclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock, oversampled by `clk` |
| cfg_enable | input | 1 | Run the transmitter |
| cfg_words | input | 6 | Slots per frame (1..32) |
| cfg_bits | input | 6 | Bits per word (1..32) |
| cfg_delay | input | 5 | Bit clocks from sync start to first data bit |
| cfg_sync_len | input | 8 | Sync width in bit clocks (0 means 1) |
| cfg_sync_active_high | input | 1 | Sync polarity |
| cfg_slot_mask | input | 32 | 1 = skip slot |
| cfg_idle_level | input | 1 | Level of `sdata` when not sending data |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_sample_rising | input | 1 | Receiver samples on rising `bclk` |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample taken this cycle |
| in_data | input | 32 | Right-justified sample |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse: active slot had no sample |

## Verification
A wrong frame position counter shows at once on `fsync`: the pulse comes at the wrong period or with the wrong width, within one frame. A wrong slot or bit counter moves data into the wrong slot or swaps bit order on `sdata`, and it also mistimes the `in_ready` pulses, which changes how many samples are taken per frame. A lost delay count or a lost "data started" flag shifts every later word by whole bit clocks. Because of this, the bench compares every launched bit of several frames against a model computed from the requirements, then compares the handshake and underrun counts.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int MAX_SLOTS = 32;
  localparam int MAX_BITS  = 32;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int BIT_W     = $clog2(MAX_BITS);
  localparam int CNT_W     = SLOT_W + 1;           // holds 1..MAX
  localparam int FPOS_W    = SLOT_W + BIT_W + 1;   // holds frame length

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitn;
  } slot_pos_t;
endpackage

// File: rtl/tdm_tx_edge.sv
module tdm_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic sample_rising,
  output logic launch
);
  logic bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  // launch on the edge the receiver does not sample on
  always_comb begin
    if (sample_rising) launch = bclk_q & ~bclk;
    else               launch = ~bclk_q & bclk;
  end
endmodule

// File: rtl/tdm_tx_fsync.sv
module tdm_tx_fsync
  import tdm_tx_pkg::*;
#(
  parameter int SYNC_LEN_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  launch,
  input  logic [CNT_W-1:0]      words,
  input  logic [CNT_W-1:0]      bits,
  input  logic [SYNC_LEN_W-1:0] sync_len,
  input  logic                  sync_high,
  output logic                  fsync
);
  logic [FPOS_W-1:0]   pos;
  logic [FPOS_W-1:0]   frame_len;
  logic [SYNC_LEN_W:0] width;
  logic                in_pulse;

  always_comb begin
    frame_len = FPOS_W'(words) * FPOS_W'(bits);
    width     = (sync_len == '0) ? (SYNC_LEN_W+1)'(1) : {1'b0, sync_len};
    in_pulse  = 32'(pos) < 32'(width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      fsync <= 1'b0;
    end else if (!en) begin
      pos   <= '0;
      fsync <= ~sync_high;
    end else if (launch) begin
      fsync <= in_pulse ? sync_high : ~sync_high;
      pos   <= (pos == frame_len - 1'b1) ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_tx_slotseq.sv
module tdm_tx_slotseq
  import tdm_tx_pkg::*;
#(
  parameter int DELAY_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 launch,
  input  logic [CNT_W-1:0]     words,
  input  logic [CNT_W-1:0]     bits,
  input  logic [DELAY_W-1:0]   delay,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 underrun,
  output logic                 emit,
  output logic                 lead_tick,
  output logic                 word_first,
  output logic [BIT_W-1:0]     bit_now
);
  slot_pos_t          cur;
  logic [DELAY_W-1:0] lead;
  logic               started;
  logic               go;
  logic               slot_on;
  logic               last_bit;
  logic               last_slot;

  always_comb begin
    go         = started | (lead == delay);
    emit       = launch & en & go;
    lead_tick  = launch & en & ~go;
    word_first = (cur.bitn == '0);
    bit_now    = cur.bitn;
    slot_on    = ~slot_mask[cur.slot];
    in_ready   = emit & word_first & slot_on;
    last_bit   = (CNT_W'(cur.bitn) == bits - 1'b1);
    last_slot  = (CNT_W'(cur.slot) == words - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      lead     <= '0;
      started  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= in_ready & ~in_valid;
      if (!en) begin
        cur     <= '0;
        lead    <= '0;
        started <= 1'b0;
      end else if (lead_tick) begin
        lead <= lead + 1'b1;
      end else if (emit) begin
        started <= 1'b1;
        if (last_bit) begin
          cur.bitn <= '0;
          cur.slot <= last_slot ? '0 : cur.slot + 1'b1;
        end else begin
          cur.bitn <= cur.bitn + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              emit,
  input  logic              lead_tick,
  input  logic              word_first,
  input  logic [BIT_W-1:0]  bit_now,
  input  logic [CNT_W-1:0]  bits,
  input  logic              lsb_first,
  input  logic              take,
  input  logic [DATA_W-1:0] in_data,
  input  logic              idle_level,
  output logic              sdata
);
  logic [DATA_W-1:0] word;
  logic              have;
  logic [BIT_W-1:0]  idx;
  logic [CNT_W-1:0]  msb_idx;

  always_comb begin
    msb_idx = bits - 1'b1 - CNT_W'(bit_now);
    idx     = lsb_first ? bit_now : msb_idx[BIT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      have  <= 1'b0;
      sdata <= 1'b1;
    end else if (!en) begin
      have  <= 1'b0;
      sdata <= idle_level;
    end else if (lead_tick) begin
      sdata <= idle_level;
    end else if (emit) begin
      if (word_first) begin
        have <= take;
        if (take) word <= in_data;
        sdata <= take ? in_data[idx] : idle_level;
      end else begin
        sdata <= have ? word[idx] : idle_level;
      end
    end
  end
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
  import tdm_tx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SYNC_LEN_W = 8,
  parameter int DELAY_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bclk,
  input  logic                  cfg_enable,
  input  logic [CNT_W-1:0]      cfg_words,
  input  logic [CNT_W-1:0]      cfg_bits,
  input  logic [DELAY_W-1:0]    cfg_delay,
  input  logic [SYNC_LEN_W-1:0] cfg_sync_len,
  input  logic                  cfg_sync_active_high,
  input  logic [MAX_SLOTS-1:0]  cfg_slot_mask,
  input  logic                  cfg_idle_level,
  input  logic                  cfg_lsb_first,
  input  logic                  cfg_sample_rising,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  fsync,
  output logic                  sdata,
  output logic                  underrun
);
  logic             launch;
  logic             emit;
  logic             lead_tick;
  logic             word_first;
  logic [BIT_W-1:0] bit_now;

  tdm_tx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk),
    .sample_rising(cfg_sample_rising), .launch(launch)
  );

  tdm_tx_fsync #(.SYNC_LEN_W(SYNC_LEN_W)) u_fsync (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .launch(launch),
    .words(cfg_words), .bits(cfg_bits), .sync_len(cfg_sync_len),
    .sync_high(cfg_sync_active_high), .fsync(fsync)
  );

  tdm_tx_slotseq #(.DELAY_W(DELAY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .launch(launch),
    .words(cfg_words), .bits(cfg_bits), .delay(cfg_delay),
    .slot_mask(cfg_slot_mask), .in_valid(in_valid), .in_ready(in_ready),
    .underrun(underrun), .emit(emit), .lead_tick(lead_tick),
    .word_first(word_first), .bit_now(bit_now)
  );

  tdm_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .emit(emit),
    .lead_tick(lead_tick), .word_first(word_first), .bit_now(bit_now),
    .bits(cfg_bits), .lsb_first(cfg_lsb_first),
    .take(in_ready & in_valid), .in_data(in_data),
    .idle_level(cfg_idle_level), .sdata(sdata)
  );
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_idle_level,
  input logic cfg_sync_active_high,
  input logic launch,
  input logic in_valid,
  input logic in_ready,
  input logic fsync,
  input logic sdata,
  input logic underrun
);
  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && $past(!cfg_enable) && $stable(cfg_idle_level) && $stable(cfg_sync_active_high))
      |-> (fsync == !cfg_sync_active_high) && (sdata == cfg_idle_level));

  p_ready_at_launch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (launch && cfg_enable));

  p_underrun_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(in_ready && !in_valid));

  p_data_moves_on_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable) && !$stable(sdata)) |-> $past(launch));
endmodule

bind tdm_frame_tx tdm_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
  .cfg_idle_level(cfg_idle_level), .cfg_sync_active_high(cfg_sync_active_high),
  .launch(launch), .in_valid(in_valid), .in_ready(in_ready),
  .fsync(fsync), .sdata(sdata), .underrun(underrun)
);

// File: tb/tdm_frame_tx_bench.sv
module tdm_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [5:0]  cfg_words = 6'd2;
  logic [5:0]  cfg_bits = 6'd16;
  logic [4:0]  cfg_delay = 5'd1;
  logic [7:0]  cfg_sync_len = 8'd0;
  logic        cfg_sync_active_high = 1'b1;
  logic [31:0] cfg_slot_mask = 32'h0;
  logic        cfg_idle_level = 1'b1;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_sample_rising = 1'b1;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        fsync;
  logic        sdata;
  logic        underrun;

  int checks = 0;
  int errors = 0;

  logic [31:0] smp [0:15];
  int          nsamp = 0;
  int          fidx;
  int          ucnt;
  logic        feed_rst = 1'b1;
  logic        fs_a, sd_a, sd_b;

  always #5 clk = ~clk;

  assign in_valid = (fidx < nsamp);
  assign in_data  = smp[fidx[3:0]];

  always @(posedge clk) begin
    if (feed_rst) begin
      fidx <= 0;
      ucnt <= 0;
    end else begin
      if (in_valid && in_ready) fidx <= fidx + 1;
      if (underrun) ucnt <= ucnt + 1;
    end
  end

  tdm_frame_tx u_tdm_frame_tx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .cfg_enable(cfg_enable),
    .cfg_words(cfg_words), .cfg_bits(cfg_bits), .cfg_delay(cfg_delay),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_active_high(cfg_sync_active_high),
    .cfg_slot_mask(cfg_slot_mask), .cfg_idle_level(cfg_idle_level),
    .cfg_lsb_first(cfg_lsb_first), .cfg_sample_rising(cfg_sample_rising),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .fsync(fsync), .sdata(sdata), .underrun(underrun)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one bit period: launch edge, wait, sampling edge, record
  task automatic bit_cycle();
    @(negedge clk) bclk = !cfg_sample_rising;
    repeat (4) @(negedge clk);
    sd_b = sdata;
    bclk = cfg_sample_rising;
    repeat (2) @(negedge clk);
    fs_a = fsync;
    sd_a = sdata;
    repeat (1) @(negedge clk);
  endtask

  task automatic idle_bclk();
    @(negedge clk) bclk = cfg_sample_rising;
    repeat (3) @(negedge clk);
  endtask

  // run nbits bit clocks from enable and compare against a model
  task automatic run_stream(input int nbits, input string dtag);
    int fl, sw, midx, exp_under, j, b, s;
    logic [31:0] cur;
    logic have, efs, esd;
    cfg_enable = 1'b0;
    feed_rst = 1'b1;
    idle_bclk();
    @(negedge clk) feed_rst = 1'b0;
    cfg_enable = 1'b1;
    fl = int'(cfg_words) * int'(cfg_bits);
    sw = (cfg_sync_len == 0) ? 1 : int'(cfg_sync_len);
    midx = 0; exp_under = 0; have = 1'b0; cur = '0;
    for (int k = 0; k < nbits; k++) begin
      bit_cycle();
      efs = ((k % fl) < sw) ? cfg_sync_active_high : !cfg_sync_active_high;
      if (k < int'(cfg_delay)) esd = cfg_idle_level;
      else begin
        j = k - int'(cfg_delay);
        b = j % int'(cfg_bits);
        s = (j / int'(cfg_bits)) % int'(cfg_words);
        if (b == 0) begin
          if (cfg_slot_mask[s]) have = 1'b0;
          else if (midx < nsamp) begin cur = smp[midx]; midx++; have = 1'b1; end
          else begin have = 1'b0; exp_under++; end
        end
        esd = have ? cur[cfg_lsb_first ? b : int'(cfg_bits) - 1 - b] : cfg_idle_level;
      end
      check(fs_a == efs, "R3", $sformatf("fsync bit %0d", k), 32'(fs_a), 32'(efs));
      check(sd_a == esd, dtag, $sformatf("sdata bit %0d", k), 32'(sd_a), 32'(esd));
      check(sd_a == sd_b, "R10", $sformatf("sdata steady at sample edge %0d", k),
            32'(sd_a), 32'(sd_b));
    end
    repeat (2) @(negedge clk);
    check(fidx == midx, "R5", "samples taken", 32'(fidx), 32'(midx));
    check(ucnt == exp_under, "R9", "underrun pulses", 32'(ucnt), 32'(exp_under));
  endtask

  task automatic load(input int n, input logic [31:0] base);
    nsamp = n;
    for (int i = 0; i < 16; i++) smp[i] = base ^ (32'h9E3779B9 * (i + 1));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(fsync == 1'b0, "R11", "reset fsync", 32'(fsync), 0);
    check(sdata == 1'b1, "R6", "reset sdata idle", 32'(sdata), 1);
    check(in_ready == 1'b0, "R12", "reset ready", 32'(in_ready), 0);
    check(underrun == 1'b0, "R9", "reset underrun", 32'(underrun), 0);
  endtask

  task automatic t_i2s();  // R1 R2 R4 R7: stereo 16 bit, delay 1, low sync
    cfg_words = 2; cfg_bits = 16; cfg_delay = 1; cfg_sync_len = 16;
    cfg_sync_active_high = 0; cfg_slot_mask = 0; cfg_idle_level = 1;
    cfg_lsb_first = 0; cfg_sample_rising = 1;
    load(6, 32'hDEAD0000);
    run_stream(96, "R2");
  endtask

  task automatic t_left_just();  // R7 R8: 24 bit, delay 0, LSB first, idle 0
    cfg_words = 2; cfg_bits = 24; cfg_delay = 0; cfg_sync_len = 0;
    cfg_sync_active_high = 1; cfg_idle_level = 0; cfg_lsb_first = 1;
    load(4, 32'hFF000000);
    run_stream(96, "R8");
  endtask

  task automatic t_tdm_mask();  // R5 R6: 4 slots of 8, slots 0 and 2 skipped
    cfg_words = 4; cfg_bits = 8; cfg_delay = 2; cfg_sync_len = 3;
    cfg_sync_active_high = 1; cfg_slot_mask = 32'h5; cfg_idle_level = 1;
    cfg_lsb_first = 0;
    load(6, 32'h12345600);
    run_stream(96, "R5");
    cfg_slot_mask = 0;
  endtask

  task automatic t_underrun();  // R9: one sample for two stereo frames
    cfg_words = 2; cfg_bits = 16; cfg_delay = 1; cfg_sync_len = 0;
    cfg_idle_level = 0; cfg_lsb_first = 0;
    load(1, 32'h0000C3A5);
    run_stream(64, "R9");
  endtask

  task automatic t_polarity();  // R10 R1: launch on rising edges, 3 slots of 32
    cfg_words = 3; cfg_bits = 32; cfg_delay = 0; cfg_sync_len = 1;
    cfg_sync_active_high = 1; cfg_idle_level = 1; cfg_sample_rising = 0;
    load(3, 32'h80000001);
    run_stream(100, "R10");
    cfg_sample_rising = 1;
  endtask

  task automatic t_disable();  // R11: outputs parked while bclk keeps running
    cfg_words = 2; cfg_bits = 8; cfg_delay = 1; cfg_sync_len = 0;
    cfg_sync_active_high = 0; cfg_idle_level = 1;
    load(8, 32'h000000AA);
    run_stream(10, "R1");
    @(negedge clk) cfg_enable = 0;
    for (int k = 0; k < 6; k++) begin
      bit_cycle();
      check(fs_a == 1'b1, "R11", "disabled fsync", 32'(fs_a), 1);
      check(sd_a == 1'b1, "R11", "disabled sdata", 32'(sd_a), 1);
    end
    run_stream(32, "R11");  // restart must begin at frame position 0
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_i2s();
    t_left_just();
    t_tdm_mask();
    t_underrun();
    t_polarity();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule